// File: doc/BRIEF.md
# Internal Data Space Router

This block sits between a CPU core's operand path and its internal data storage. It takes one byte-wide operand address together with the kind of access the instruction uses, and steers it to one of three separate targets. The targets are a 128-byte low scratch RAM, a 128-byte high RAM, and an external special-register port. In this way one 8-bit address reaches 384 bytes: the range 80H–FFH means special registers when it is named directly and high RAM when it is reached through a pointer.

The block also handles two other operand forms. Register operands (numbers 0–7) are relocated into one of four 8-byte banks at the bottom of the low RAM, chosen by a 2-bit bank input. Single-bit operands are turned into a byte and a bit position. A bit write is carried out as a read-modify-write in one cycle, so only the addressed bit changes. Reads are combinational. Writes land on the rising clock edge. The special registers themselves live outside the block.

The access port has no handshake: every cycle is an access, and `wr_en` qualifies the write. The block never stalls, so it needs no back-pressure.

Top module: `idata_space_router`

## Requirements
- R1: With `mode` = 0 (direct) or 1 (pointer) and `addr` below 80H, the access reaches low RAM byte `addr`. A byte written one way reads back the other way.
- R2: With `mode` = 0 and `addr` at or above 80H, `sfr_sel` is 1, `sfr_addr` equals `addr`, `rd_data` equals `sfr_rdata`, and `sfr_we`/`sfr_wdata` follow `wr_en`/`wr_data`. No internal RAM byte changes.
- R3: With `mode` = 1, `addr` at or above 80H and `UPPER_EN` = 1, the access reaches high RAM byte `addr`-80H. This RAM is separate from the special registers, and `sfr_sel` stays 0.
- R4: With `UPPER_EN` = 0, a pointer read at or above 80H returns FFH. A pointer write there changes nothing.
- R5: With `mode` = 2 (register), the access reaches low RAM byte `bank`*8 + `addr[2:0]`. `addr[7:3]` is ignored.
- R6: With `mode` = 3 (bit) and `addr` = b below 80H, the access reaches byte 20H + (b>>3), bit b&7. `rd_data` is {7'b0, bit}. A write stores `wr_data[0]` into that bit only.
- R7: With `mode` = 3 and b at or above 80H, `sfr_sel` is 1 and `sfr_addr` = b & F8H. `rd_data[0]` is bit b&7 of `sfr_rdata`, and `sfr_wdata` is `sfr_rdata` with that bit replaced by `wr_data[0]`.
- R8: A clock edge with `rst_n` low clears every internal RAM byte to 00H.
- R9: `sfr_sel` is 0 for register accesses and for low-address direct, pointer and bit accesses. `sfr_we` is never 1 while `sfr_sel` is 0.
- R10: A clock edge with `wr_en` low changes no RAM byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | 0 direct, 1 pointer, 2 register, 3 bit |
| addr | input | 8 | Operand address, register number or bit address |
| bank | input | 2 | Active register bank |
| wr_en | input | 1 | Write this cycle |
| wr_data | input | 8 | Write byte (bit 0 in bit mode) |
| rd_data | output | 8 | Read byte (bit in bit 0 for bit mode) |
| sfr_sel | output | 1 | Access targets the special-register port |
| sfr_addr | output | 8 | Special-register byte address |
| sfr_we | output | 1 | Special-register write strobe |
| sfr_wdata | output | 8 | Special-register write byte |
| sfr_rdata | input | 8 | Special-register read byte |

## Verification
The hardest case to reach is proving that the two halves sharing 80H–FFH really are separate. A direct write to one of those addresses must leave the high RAM byte at the same address untouched. The stimulus first fills all of high RAM through pointer writes, then issues direct writes to every address from 80H to FFH, then sweeps pointer reads to confirm that nothing moved.

The bench runs a second instance with the high RAM removed alongside the first, driven by the same inputs. After the same pointer writes, it must read FFH in that range and keep a low RAM identical to the model's.

// File: rtl/idm_pkg.sv
package idm_pkg;
  localparam int IDM_AW     = 8;
  localparam int IDM_DW     = 8;
  localparam int IDM_HALF   = 1 << (IDM_AW - 1);
  localparam int IDM_BANK_W = 2;
  localparam int IDM_REG_W  = 3;
  localparam int IDM_BIT_W  = $clog2(IDM_DW);
  localparam logic [IDM_AW-1:0] IDM_BIT_BASE = 8'h20;

  typedef enum logic [1:0] {
    IDM_DIRECT   = 2'd0,
    IDM_POINTER  = 2'd1,
    IDM_REGISTER = 2'd2,
    IDM_BITOP    = 2'd3
  } idm_mode_e;

  typedef enum logic [1:0] {
    TGT_LOWER = 2'd0,
    TGT_UPPER = 2'd1,
    TGT_SFR   = 2'd2,
    TGT_NONE  = 2'd3
  } idm_target_e;

  typedef struct packed {
    idm_target_e          target;
    logic [IDM_AW-1:0]    byte_addr;
    logic [IDM_BIT_W-1:0] bit_pos;
    logic                 is_bit;
  } idm_dec_t;
endpackage

// File: rtl/idm_decode.sv
module idm_decode
  import idm_pkg::*;
#(
  parameter bit UPPER_EN = 1'b1
) (
  input  logic [1:0]            mode,
  input  logic [IDM_AW-1:0]     addr,
  input  logic [IDM_BANK_W-1:0] bank,
  output idm_dec_t              dec
);
  localparam int PAD_W = IDM_AW - IDM_BANK_W - IDM_REG_W;
  localparam int IDX_W = IDM_AW - 1 - IDM_BIT_W;

  always_comb begin
    dec.target    = TGT_LOWER;
    dec.byte_addr = addr;
    dec.bit_pos   = '0;
    dec.is_bit    = 1'b0;
    unique case (idm_mode_e'(mode))
      IDM_DIRECT:   dec.target = addr[IDM_AW-1] ? TGT_SFR : TGT_LOWER;
      IDM_POINTER: begin
        if (addr[IDM_AW-1]) dec.target = UPPER_EN ? TGT_UPPER : TGT_NONE;
        else                dec.target = TGT_LOWER;
      end
      IDM_REGISTER: dec.byte_addr = {{PAD_W{1'b0}}, bank, addr[IDM_REG_W-1:0]};
      IDM_BITOP: begin
        dec.is_bit  = 1'b1;
        dec.bit_pos = addr[IDM_BIT_W-1:0];
        if (addr[IDM_AW-1]) begin
          dec.target    = TGT_SFR;
          dec.byte_addr = {addr[IDM_AW-1:IDM_BIT_W], {IDM_BIT_W{1'b0}}};
        end else begin
          dec.byte_addr = IDM_BIT_BASE + {{(IDM_AW-IDX_W){1'b0}}, addr[IDM_AW-2:IDM_BIT_W]};
        end
      end
      default: dec.target = TGT_NONE;
    endcase
  end
endmodule

// File: rtl/idm_ram.sv
module idm_ram #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/idata_space_router.sv
module idata_space_router
  import idm_pkg::*;
#(
  parameter bit UPPER_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [IDM_AW-1:0] addr,
  input  logic [1:0]        bank,
  input  logic              wr_en,
  input  logic [IDM_DW-1:0] wr_data,
  output logic [IDM_DW-1:0] rd_data,
  output logic              sfr_sel,
  output logic [IDM_AW-1:0] sfr_addr,
  output logic              sfr_we,
  output logic [IDM_DW-1:0] sfr_wdata,
  input  logic [IDM_DW-1:0] sfr_rdata
);
  localparam int IDX_W = $clog2(IDM_HALF);

  idm_dec_t          dec;
  logic [IDM_DW-1:0] lo_rdata, up_rdata, cur_byte, new_byte, bit_mask;
  logic              lo_we;

  idm_decode #(.UPPER_EN(UPPER_EN)) u_dec (
    .mode (mode), .addr (addr), .bank (bank), .dec (dec)
  );

  assign lo_we = wr_en && (dec.target == TGT_LOWER);

  idm_ram #(.DEPTH(IDM_HALF), .DW(IDM_DW)) u_lower (
    .clk (clk), .rst_n (rst_n), .we (lo_we),
    .idx (dec.byte_addr[IDX_W-1:0]), .wdata (new_byte), .rdata (lo_rdata)
  );

  generate
    if (UPPER_EN) begin : g_upper
      logic up_we;
      assign up_we = wr_en && (dec.target == TGT_UPPER);
      idm_ram #(.DEPTH(IDM_HALF), .DW(IDM_DW)) u_upper (
        .clk (clk), .rst_n (rst_n), .we (up_we),
        .idx (dec.byte_addr[IDX_W-1:0]), .wdata (new_byte), .rdata (up_rdata)
      );
    end else begin : g_no_upper
      assign up_rdata = '1;
    end
  endgenerate

  always_comb begin
    unique case (dec.target)
      TGT_LOWER: cur_byte = lo_rdata;
      TGT_UPPER: cur_byte = up_rdata;
      TGT_SFR:   cur_byte = sfr_rdata;
      default:   cur_byte = '1;
    endcase
  end

  assign bit_mask = {{(IDM_DW-1){1'b0}}, 1'b1} << dec.bit_pos;
  assign new_byte = dec.is_bit ? ((cur_byte & ~bit_mask) | (wr_data[0] ? bit_mask : '0))
                               : wr_data;
  assign rd_data  = dec.is_bit ? {{(IDM_DW-1){1'b0}}, cur_byte[dec.bit_pos]} : cur_byte;

  assign sfr_sel   = (dec.target == TGT_SFR);
  assign sfr_addr  = dec.byte_addr;
  assign sfr_we    = wr_en && sfr_sel;
  assign sfr_wdata = new_byte;
endmodule

// File: rtl/idm_router_chk.sv
module idm_router_chk
  import idm_pkg::*;
#(
  parameter bit UPPER_EN = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic [7:0] addr,
  input logic [1:0] bank,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       sfr_sel,
  input logic [7:0] sfr_addr,
  input logic       sfr_we,
  input logic [7:0] sfr_wdata,
  input logic [7:0] sfr_rdata
);
  AST_DIRECT_HIGH_TO_SFR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == IDM_DIRECT && addr[7]) |-> (sfr_sel && sfr_addr == addr && rd_data == sfr_rdata)); // R2
  AST_POINTER_NEVER_SFR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == IDM_POINTER) |-> !sfr_sel); // R3
  AST_NO_UPPER_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (!UPPER_EN && mode == IDM_POINTER && addr[7]) |-> rd_data == 8'hFF); // R4
  AST_REG_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode == IDM_REGISTER && wr_en) && mode == IDM_POINTER &&
     addr == {3'b000, $past(bank), $past(addr[2:0])}) |-> rd_data == $past(wr_data)); // R5
  AST_BIT_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode == IDM_BITOP && !addr[7] && wr_en) && mode == IDM_BITOP &&
     addr == $past(addr)) |-> rd_data == {7'b0, $past(wr_data[0])}); // R6
  AST_SFR_BIT_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == IDM_BITOP && addr[7]) |->
      (sfr_sel && ((sfr_wdata ^ sfr_rdata) & ~(8'h01 << addr[2:0])) == 8'h00 &&
       sfr_wdata[addr[2:0]] == wr_data[0])); // R7
  AST_SFR_QUIET_ELSEWHERE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == IDM_REGISTER || !addr[7]) |-> (!sfr_sel && !sfr_we)); // R9
  AST_NO_WRITE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> !sfr_we); // R10
endmodule

bind idata_space_router idm_router_chk #(.UPPER_EN(UPPER_EN)) u_chk (.*);

// File: tb/idata_space_router_test.sv
`timescale 1ns/1ps
module idata_space_router_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] addr = 8'h00;
  logic [1:0] bank = 2'd0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_a, rd_b, sfr_addr_a, sfr_addr_b, sfr_wdata_a, sfr_wdata_b;
  logic sfr_sel_a, sfr_sel_b, sfr_we_a, sfr_we_b;
  logic [7:0] ref_lo [128];
  logic [7:0] ref_up [128];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] sfr_model(input logic [7:0] a);
    return a ^ 8'h5A;
  endfunction

  idata_space_router #(.UPPER_EN(1'b1)) uut (
    .clk (clk), .rst_n (rst_n), .mode (mode), .addr (addr), .bank (bank),
    .wr_en (wr_en), .wr_data (wr_data), .rd_data (rd_a), .sfr_sel (sfr_sel_a),
    .sfr_addr (sfr_addr_a), .sfr_we (sfr_we_a), .sfr_wdata (sfr_wdata_a),
    .sfr_rdata (sfr_model(sfr_addr_a))
  );

  idata_space_router #(.UPPER_EN(1'b0)) uut_small (
    .clk (clk), .rst_n (rst_n), .mode (mode), .addr (addr), .bank (bank),
    .wr_en (wr_en), .wr_data (wr_data), .rd_data (rd_b), .sfr_sel (sfr_sel_b),
    .sfr_addr (sfr_addr_b), .sfr_we (sfr_we_b), .sfr_wdata (sfr_wdata_b),
    .sfr_rdata (sfr_model(sfr_addr_b))
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h (mode=%0d addr=%02h bank=%0d)",
               req, got, exp, mode, addr, bank);
    end
  endtask

  task automatic drive(input logic [1:0] m, input logic [7:0] a, input logic [1:0] b,
                       input logic we, input logic [7:0] d);
    @(negedge clk);
    mode = m; addr = a; bank = b; wr_en = we; wr_data = d;
    #1;
  endtask

  task automatic rd_ptr(input logic [7:0] a);
    drive(2'd1, a, 2'd0, 1'b0, 8'h00);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) begin ref_lo[i] = 8'h00; ref_up[i] = 8'h00; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R8: reset clears both RAMs
    for (int a = 0; a < 256; a++) begin
      rd_ptr(a[7:0]);
      chk("R8", rd_a, 8'h00);
      if (a < 128) chk("R8", rd_b, 8'h00);
    end

    // R1: direct writes to low RAM, pointer read back; R9 quiet strobe
    for (int a = 0; a < 128; a++) begin
      ref_lo[a] = 8'(a * 7 + 3);
      drive(2'd0, a[7:0], 2'd0, 1'b1, ref_lo[a]);
      chk("R9", {7'b0, sfr_sel_a | sfr_we_a}, 8'h00);
    end
    for (int a = 0; a < 128; a++) begin
      rd_ptr(a[7:0]);
      chk("R1", rd_a, ref_lo[a]);
    end
    // R1: pointer write, direct read
    for (int a = 64; a < 72; a++) begin
      ref_lo[a] = 8'(a ^ 8'h3C);
      drive(2'd1, a[7:0], 2'd0, 1'b1, ref_lo[a]);
      drive(2'd0, a[7:0], 2'd0, 1'b0, 8'h00);
      chk("R1", rd_a, ref_lo[a]);
    end

    // R5: register mode with junk in addr[7:3]
    for (int b = 0; b < 4; b++) begin
      for (int n = 0; n < 8; n++) begin
        ref_lo[b*8+n] = 8'(8'hB0 + b*16 + n);
        drive(2'd2, 8'(n | 8'hA8), 2'(b), 1'b1, ref_lo[b*8+n]);
        chk("R9", {7'b0, sfr_sel_a}, 8'h00);
      end
    end
    for (int a = 0; a < 40; a++) begin
      rd_ptr(a[7:0]);
      chk("R5", rd_a, ref_lo[a]);
    end

    // R6: bit writes into 20H-2FH, bit read back and byte check
    for (int b = 0; b < 128; b++) begin
      logic v;
      v = (b % 3 == 0);
      ref_lo[32 + b/8][b%8] = v;
      drive(2'd3, b[7:0], 2'd0, 1'b1, {7'b0, v});
      drive(2'd3, b[7:0], 2'd0, 1'b0, 8'h00);
      chk("R6", rd_a, {7'b0, v});
    end
    for (int a = 32; a < 48; a++) begin
      rd_ptr(a[7:0]);
      chk("R6", rd_a, ref_lo[a]);
    end

    // R10: no write enable, nothing changes
    for (int a = 0; a < 128; a += 5) begin
      drive(2'd0, a[7:0], 2'd0, 1'b0, ~ref_lo[a]);
      @(posedge clk);
      rd_ptr(a[7:0]);
      chk("R10", rd_a, ref_lo[a]);
    end

    // R3: pointer writes to high RAM
    for (int a = 128; a < 256; a++) begin
      ref_up[a-128] = 8'(a ^ 8'hC3);
      drive(2'd1, a[7:0], 2'd0, 1'b1, ref_up[a-128]);
      chk("R3", {7'b0, sfr_sel_a}, 8'h00);
    end
    // R2: direct writes reach the register port only
    for (int a = 128; a < 256; a++) begin
      drive(2'd0, a[7:0], 2'd0, 1'b1, 8'(a + 1));
      chk("R2", {6'b0, sfr_sel_a, sfr_we_a}, 8'h03);
      chk("R2", sfr_addr_a, a[7:0]);
      chk("R2", sfr_wdata_a, 8'(a + 1));
      chk("R2", rd_a, sfr_model(a[7:0]));
    end
    for (int a = 128; a < 256; a++) begin
      rd_ptr(a[7:0]);
      chk("R3", rd_a, ref_up[a-128]);
    end

    // R7: bit ops above 7FH go to the register port
    for (int b = 128; b < 256; b++) begin
      logic [7:0] base, exp_w;
      logic v;
      v = b[0] ^ b[4];
      base = sfr_model(8'(b & 8'hF8));
      exp_w = base;
      exp_w[b%8] = v;
      drive(2'd3, b[7:0], 2'd0, 1'b1, {7'b0, v});
      chk("R7", sfr_addr_a, 8'(b & 8'hF8));
      chk("R7", sfr_wdata_a, exp_w);
      chk("R7", rd_a, {7'b0, base[b%8]});
    end

    // R4: small variant returns FFH above 7FH and kept its low RAM
    for (int a = 128; a < 256; a++) begin
      rd_ptr(a[7:0]);
      chk("R4", rd_b, 8'hFF);
    end
    for (int a = 0; a < 128; a++) begin
      rd_ptr(a[7:0]);
      chk("R4", rd_b, ref_lo[a]);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule